// File: doc/BRIEF.md
# Burst Column Sequencer with Byte-Lane Masks

This block steps through one read or write burst for a synchronous graphics DRAM model. When a column command is accepted, the block latches the start column, the bank, the direction and the burst settings. From the next cycle it presents one column address per beat. In linear order the column counts upward and rolls over at the end of the 256-column page. In wrap order it circles inside the aligned block whose size is the burst length.

A fixed-length burst ends by itself after its beat count. It can end earlier in three ways: a burst-stop, a new column command, or a precharge aimed at the same bank. A full-page burst has no end of its own and keeps circling the page until one of those events arrives. A burst flagged for auto-precharge is locked: nothing can cut it short. The flag is void on a full-page burst.

Byte lanes are gated by a per-cycle mask. It applies at once to write beats. For read data it applies two cycles after it is sampled. Read data-valid follows each read beat by the programmed CAS latency, counted from the command.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, rd_valid, wr_be and rd_be are all zero until a command is accepted.
- R2: Length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. Beat 0 appears in the cycle after the command. In linear order (type bit 0), beat i uses column (start+i) mod 256.
- R3: In wrap order (type bit 1), beat i of an L-beat burst uses column (start AND NOT (L-1)) OR ((start+i) AND (L-1)).
- R4: Length code 111 in linear order is a full-page burst. It gives columns (start+i) mod 256 without end, running past column 255 back to 0, until a stop, a new command or a same-bank precharge ends it.
- R5: A command with a reserved length (100, 101, 110, or 111 with type bit 1) is ignored. If the block is idle it stays idle, and a running burst continues unchanged.
- R6: If stop is high during a beat of an unlocked burst, that beat is the last one and col_valid is low in the next cycle. Read beats already issued still produce rd_valid.
- R7: A legal command during an unlocked burst replaces it. Beat 0 of the new burst appears in the next cycle. A command takes priority over a stop or precharge in the same cycle.
- R8: A precharge whose bank equals the burst's bank ends an unlocked burst in the same way as a stop. A precharge to any other bank has no effect.
- R9: A fixed-length burst issued with auto-precharge always runs all of its beats. Stop, new commands and same-bank precharge are ignored while it runs.
- R10: The auto-precharge flag has no effect on a full-page burst, so a stop still ends it.
- R11: During a write beat, wr_be equals the bitwise inverse of dqm in the same cycle (bit n is byte lane n, dqm high masks the lane). At all other times wr_be is zero.
- R12: With latency CL set to 1, 2 or 3, rd_valid is high in cycle c+CL+i for each read beat i issued by a command in cycle c. This is CL-1 cycles after that beat's column is shown.
- R13: When rd_valid is high, rd_be equals the inverse of dqm as sampled two cycles earlier. Otherwise rd_be is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 3 | Burst length code, sampled with a command |
| cfg_wrap | input | 1 | Burst order: 0 linear, 1 wrap |
| cfg_cas | input | 2 | Read latency in cycles (1 to 3) |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_write | input | 1 | Command direction: 1 write, 0 read |
| cmd_auto_pc | input | 1 | Command carries auto-precharge |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 8 | Start column |
| stop | input | 1 | Burst-stop request |
| pc_valid | input | 1 | Precharge request this cycle |
| pc_bank | input | 2 | Bank of the precharge |
| dqm | input | 4 | Per-lane byte mask, high masks |
| col_valid | output | 1 | A beat is issued this cycle |
| col_write | output | 1 | Direction of the current beat |
| col_addr | output | 8 | Column of the current beat |
| wr_be | output | 4 | Write byte enables |
| rd_valid | output | 1 | Read data valid |
| rd_be | output | 4 | Read byte enables |

## Verification
A wrong beat index or base shows up as a wrong col_addr in the very next beat. A wrong end count or lock bit shows up as col_valid staying high one cycle too long, or dropping one cycle too soon. A fault in the latency or mask delay lines shows up only CL-1 or two cycles after the read beat that fed it. The bench therefore follows the ports every cycle with an arithmetic reference and compares all six outputs in each cycle, so a fault is reported within three cycles of its cause.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam logic [2:0] LEN_PAGE = 3'b111;

    // Only the power-of-two codes and the full page (linear only) are legal.
    function automatic logic len_ok(input logic [2:0] code, input logic wrap);
        return (!code[2]) || (code == LEN_PAGE && !wrap);
    endfunction

endpackage

// File: rtl/bsq_col_gen.sv
module bsq_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] lmask,
    input  logic             wrap,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;

    always_comb begin
        sum = base + idx;
        if (wrap) begin
            col = (base & ~lmask) | (sum & lmask);
        end else begin
            col = sum;
        end
    end
endmodule

// File: rtl/bsq_lat_pipe.sv
module bsq_lat_pipe #(
    parameter int LANES       = 4,
    parameter int MAX_CL      = 3,
    parameter int RD_MASK_LAT = 2,
    parameter int CL_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_rd,
    input  logic [CL_W-1:0]  cas,
    input  logic [LANES-1:0] dqm,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_be
);
    localparam int VD = MAX_CL - 1;

    logic [VD-1:0]     v_d, v_q;
    logic [MAX_CL-1:0] v_all;
    int                sel;

    always_comb begin
        v_all = {v_q, beat_rd};
        v_d   = v_all[VD-1:0];
        if (cas == '0) begin
            sel = 0;
        end else if (int'(cas) > MAX_CL) begin
            sel = MAX_CL - 1;
        end else begin
            sel = int'(cas) - 1;
        end
        rd_valid = v_all[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    generate
        if (RD_MASK_LAT == 0) begin : g_mask_now
            assign rd_be = rd_valid ? ~dqm : '0;
        end else begin : g_mask_pipe
            logic [LANES-1:0] m_d [RD_MASK_LAT];
            logic [LANES-1:0] m_q [RD_MASK_LAT];

            always_comb begin
                m_d[0] = dqm;
                for (int k = 1; k < RD_MASK_LAT; k++) m_d[k] = m_q[k-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < RD_MASK_LAT; k++) m_q[k] <= '0;
                end else begin
                    for (int k = 0; k < RD_MASK_LAT; k++) m_q[k] <= m_d[k];
                end
            end

            assign rd_be = rd_valid ? ~m_q[RD_MASK_LAT-1] : '0;
        end
    endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W       = 8,
    parameter int LANES       = 4,
    parameter int BANK_W      = 2,
    parameter int MAX_CL      = 3,
    parameter int RD_MASK_LAT = 2,
    localparam int CL_W       = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_len,
    input  logic              cfg_wrap,
    input  logic [CL_W-1:0]   cfg_cas,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_auto_pc,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              stop,
    input  logic              pc_valid,
    input  logic [BANK_W-1:0] pc_bank,
    input  logic [LANES-1:0]  dqm,
    output logic              col_valid,
    output logic              col_write,
    output logic [COL_W-1:0]  col_addr,
    output logic [LANES-1:0]  wr_be,
    output logic              rd_valid,
    output logic [LANES-1:0]  rd_be
);
    import bsq_pkg::*;

    typedef struct packed {
        logic              act;
        logic              wr;
        logic              ap;
        logic              full;
        logic              wrap;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  idx;
        logic [COL_W-1:0]  lmask;
        logic [BANK_W-1:0] bank;
    } seq_t;

    seq_t s_d, s_q;
    logic take, last, cut, locked, pc_hit;

    function automatic logic [COL_W-1:0] code_mask(input logic [2:0] code);
        if (code == LEN_PAGE) return '1;
        return (COL_W'(1) << code[1:0]) - COL_W'(1);
    endfunction

    always_comb begin
        locked = s_q.act && s_q.ap;
        take   = cmd_valid && len_ok(cfg_len, cfg_wrap) && !locked;
        pc_hit = pc_valid && (pc_bank == s_q.bank);
        cut    = s_q.act && !s_q.ap && (stop || pc_hit);
        last   = s_q.act && !s_q.full && (s_q.idx == s_q.lmask);

        s_d = s_q;
        if (take) begin
            s_d.act   = 1'b1;
            s_d.wr    = cmd_write;
            s_d.full  = (cfg_len == LEN_PAGE);
            s_d.ap    = cmd_auto_pc && (cfg_len != LEN_PAGE);
            s_d.wrap  = cfg_wrap;
            s_d.base  = cmd_col;
            s_d.idx   = '0;
            s_d.lmask = code_mask(cfg_len);
            s_d.bank  = cmd_bank;
        end else if (cut || last) begin
            s_d.act = 1'b0;
            s_d.ap  = 1'b0;
        end else if (s_q.act) begin
            s_d.idx = s_q.idx + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bsq_col_gen #(.COL_W(COL_W)) u_col (
        .base (s_q.base),
        .idx  (s_q.idx),
        .lmask(s_q.lmask),
        .wrap (s_q.wrap),
        .col  (col_addr)
    );

    assign col_valid = s_q.act;
    assign col_write = s_q.wr;
    assign wr_be     = (s_q.act && s_q.wr) ? ~dqm : '0;

    bsq_lat_pipe #(
        .LANES      (LANES),
        .MAX_CL     (MAX_CL),
        .RD_MASK_LAT(RD_MASK_LAT),
        .CL_W       (CL_W)
    ) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_rd (s_q.act && !s_q.wr),
        .cas     (cfg_cas),
        .dqm     (dqm),
        .rd_valid(rd_valid),
        .rd_be   (rd_be)
    );
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
    parameter int COL_W = 8,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_write,
    input logic [LANES-1:0] wr_be,
    input logic [LANES-1:0] dqm,
    input logic             rd_valid,
    input logic [LANES-1:0] rd_be,
    input logic             stop,
    input logic             cmd_valid,
    input logic             pc_valid,
    input logic             ap_q,
    input logic             full_q,
    input logic             wrap_q,
    input logic             take,
    input logic             last
);
    assert_wbe_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_write) |-> ((wr_be & dqm) == '0));

    assert_rbe_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_be == '0));

    assert_ap_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && ap_q && !last) |=> col_valid);

    assert_page_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && full_q && !stop && !pc_valid && !cmd_valid) |=> col_valid);

    assert_lin_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !wrap_q && !last && !take && !stop && !pc_valid)
        |=> (col_valid && col_addr == COL_W'($past(col_addr) + 1'b1)));

    assert_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop && !ap_q && !cmd_valid) |=> !col_valid);
endmodule

bind burst_col_seq bsq_chk #(.COL_W(COL_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_valid(col_valid),
    .col_addr (col_addr),
    .col_write(col_write),
    .wr_be    (wr_be),
    .dqm      (dqm),
    .rd_valid (rd_valid),
    .rd_be    (rd_be),
    .stop     (stop),
    .cmd_valid(cmd_valid),
    .pc_valid (pc_valid),
    .ap_q     (s_q.ap),
    .full_q   (s_q.full),
    .wrap_q   (s_q.wrap),
    .take     (take),
    .last     (last)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_len = '0;
    logic       cfg_wrap = 1'b0;
    logic [1:0] cfg_cas = 2'd1;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_auto_pc = 1'b0;
    logic [1:0] cmd_bank = '0;
    logic [7:0] cmd_col = '0;
    logic       stop = 1'b0, pc_valid = 1'b0;
    logic [1:0] pc_bank = '0;
    logic [3:0] dqm = '0;
    logic       col_valid, col_write, rd_valid;
    logic [7:0] col_addr;
    logic [3:0] wr_be, rd_be;

    always #2 clk = ~clk;

    burst_col_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_wrap(cfg_wrap),
        .cfg_cas(cfg_cas), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_auto_pc(cmd_auto_pc), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .stop(stop), .pc_valid(pc_valid), .pc_bank(pc_bank), .dqm(dqm),
        .col_valid(col_valid), .col_write(col_write), .col_addr(col_addr),
        .wr_be(wr_be), .rd_valid(rd_valid), .rd_be(rd_be)
    );

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";

    // reference state, derived from the requirements
    bit       m_act, m_wr, m_ap, m_full, m_wrap;
    int       m_base, m_idx, m_len, m_bank;
    bit       h1, h2;
    bit [3:0] dq1, dq2;

    function automatic int exp_col();
        if (m_wrap) return (m_base & ~(m_len - 1) & 255) | ((m_base + m_idx) & (m_len - 1));
        return (m_base + m_idx) % 256;
    endfunction

    task automatic miscompare(string req, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    endtask

    task automatic check_now();
        bit       rv;
        bit [3:0] wbe, rbe;
        #1;
        vectors++;
        if (col_valid !== m_act) miscompare(cur_req, "col_valid", int'(col_valid), int'(m_act));
        if (m_act && col_addr !== 8'(exp_col())) miscompare(cur_req, "col_addr", int'(col_addr), exp_col());
        if (m_act && col_write !== m_wr) miscompare(cur_req, "col_write", int'(col_write), int'(m_wr));
        wbe = (m_act && m_wr) ? ~dqm : 4'h0;
        if (wr_be !== wbe) miscompare("R11", "wr_be", int'(wr_be), int'(wbe));
        rv = (cfg_cas == 2'd1) ? (m_act && !m_wr) : (cfg_cas == 2'd2) ? h1 : h2;
        if (rd_valid !== rv) miscompare("R12", "rd_valid", int'(rd_valid), int'(rv));
        rbe = rv ? ~dq2 : 4'h0;
        if (rd_be !== rbe) miscompare("R13", "rd_be", int'(rd_be), int'(rbe));
    endtask

    task automatic model_update();
        bit legal, take, term;
        h2 = h1; h1 = m_act && !m_wr;
        dq2 = dq1; dq1 = dqm;
        legal = (cfg_len <= 3'd3) || (cfg_len == 3'd7 && !cfg_wrap);
        take  = cmd_valid && legal && !(m_act && m_ap);
        term  = m_act && !m_ap && (stop || (pc_valid && int'(pc_bank) == m_bank));
        if (take) begin
            m_act = 1; m_wr = cmd_write; m_wrap = cfg_wrap; m_base = int'(cmd_col);
            m_bank = int'(cmd_bank); m_idx = 0;
            m_full = (cfg_len == 3'd7);
            m_len  = m_full ? 256 : (1 << cfg_len);
            m_ap   = cmd_auto_pc && !m_full;
        end else if (m_act) begin
            if (term || (!m_full && m_idx == m_len - 1)) begin
                m_act = 0; m_ap = 0;
            end else begin
                m_idx = (m_idx + 1) % 256;
            end
        end
    endtask

    task automatic tick();
        check_now();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cmd_valid = 0; stop = 0; pc_valid = 0;
        dqm = 4'($urandom);
    endtask

    task automatic issue(input int code, input bit wrap, input bit wr, input bit ap,
                         input int bank, input int col);
        cfg_len = 3'(code); cfg_wrap = wrap; cmd_write = wr; cmd_auto_pc = ap;
        cmd_bank = 2'(bank); cmd_col = 8'(col); cmd_valid = 1;
        tick();
    endtask

    task automatic run_out(input int limit);
        int n = 0;
        while (m_act && n < limit) begin tick(); n++; end
        if (m_act) begin stop = 1; tick(); end
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int starts [4] = '{8'h00, 8'h05, 8'hFE, 8'h7B};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        cur_req = "R1";
        repeat (4) tick();

        // R2 R3 R4 R5 R11 R12 R13: sweep of lengths, orders, latencies, starts
        for (int cl = 1; cl <= 3; cl++) begin
            cfg_cas = 2'(cl);
            for (int wr = 0; wr < 2; wr++)
                for (int wp = 0; wp < 2; wp++)
                    for (int code = 0; code < 8; code++)
                        foreach (starts[s]) begin
                            if (code > 3 && !(code == 7 && wp == 0)) cur_req = "R5";
                            else if (code == 7) cur_req = "R4";
                            else if (wp == 1) cur_req = "R3";
                            else cur_req = "R2";
                            issue(code, bit'(wp), bit'(wr), 1'b0, s, starts[s]);
                            run_out(260);
                        end
        end

        cfg_cas = 2'd2;
        // R5: reserved code while a burst runs
        cur_req = "R5";
        issue(3, 0, 0, 0, 1, 8'h10); tick(); tick();
        issue(5, 0, 1, 0, 1, 8'h40); run_out(20);
        // R6: stop in the middle
        cur_req = "R6";
        issue(3, 0, 0, 0, 0, 8'h20); tick(); tick(); stop = 1; tick(); run_out(20);
        // R7: replacement, and command beats stop in the same cycle
        cur_req = "R7";
        issue(3, 1, 1, 0, 0, 8'h33); tick();
        stop = 1; issue(2, 0, 0, 0, 2, 8'hFD); run_out(20);
        // R8: other-bank precharge ignored, same bank ends
        cur_req = "R8";
        issue(3, 0, 0, 0, 2, 8'h50); pc_valid = 1; pc_bank = 2'd1; tick();
        pc_valid = 1; pc_bank = 2'd2; tick(); run_out(20);
        // R9: locked burst
        cur_req = "R9";
        issue(3, 1, 0, 1, 3, 8'h0E); stop = 1; tick();
        issue(1, 0, 1, 0, 0, 8'h99);
        pc_valid = 1; pc_bank = 2'd3; tick(); run_out(20);
        // R10: auto-precharge void on full page
        cur_req = "R10";
        issue(7, 0, 0, 1, 1, 8'hF0); repeat (20) tick(); stop = 1; tick(); run_out(300);

        // mixed interruptions R6 R7 R8 R9 R10
        cur_req = "R7";
        for (int i = 0; i < 6000; i++) begin
            int codes [6] = '{0, 1, 2, 3, 7, 5};
            if (i == 3000) cfg_cas = 2'd3;
            if (i == 4500) cfg_cas = 2'd1;
            cfg_len = 3'(codes[$urandom_range(5)]);
            cfg_wrap = bit'($urandom_range(1));
            cmd_write = bit'($urandom_range(1));
            cmd_auto_pc = bit'($urandom_range(1));
            cmd_bank = 2'($urandom); cmd_col = 8'($urandom);
            cmd_valid = ($urandom_range(5) == 0);
            stop = ($urandom_range(11) == 0);
            pc_valid = ($urandom_range(9) == 0);
            pc_bank = 2'($urandom);
            tick();
        end
        run_out(300);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule